// File: doc/BRIEF.md
# CAN Fault Confinement State Controller

This block keeps the error bookkeeping of a CAN node. A protocol engine reports single-cycle event pulses: receive errors, receive errors caused by dominant bits, good receptions, transmit errors and good transmissions. The block updates a receive error counter and a transmit error counter from these pulses. From the counters it derives one of three node error states: error active, error passive or bus off.

Once the node is bus off, the counters freeze. The only way out is a strobe from software, which returns the node straight to error active. That strobe clears the two counters and the bus-off flag and touches nothing else. Separately, a listen-only control bit keeps the node silent on the wire. The block qualifies every bus-driving request from the engine (data frame, error flag, acknowledge slot) against the listen-only bit and the error state. It then passes back a per-request enable.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, both counters read 0, `err_state` is 0 (error active) and `bus_off` is 0.
- R2: Outside bus off, the receive counter changes once per clock, by the first rule that applies. A dominant-bit error (`rx_err_dom`) adds 8. Otherwise `rx_err` adds 1. Otherwise `rx_ok` subtracts 1 if the counter is nonzero. The counter saturates at 255 and never wraps.
- R3: Outside bus off, `tx_err` adds 8 to the transmit counter. Otherwise `tx_ok` subtracts 1 if the counter is nonzero.
- R4: `err_state` takes three values. It is 2 when the node is bus off. Otherwise it is 1 when either counter is 128 or more. Otherwise it is 0. The value 3 never appears.
- R5: `bus_off` goes to 1 in the same cycle that the transmit counter first exceeds 255. While `bus_off` is 1 and no force strobe is given, both counters hold their values and all events are ignored.
- R6: A `force_ret` pulse given while bus off clears both counters and `bus_off` at the next edge, so `err_state` becomes 0. Events in that same cycle are discarded.
- R7: A `force_ret` pulse given when the node is not bus off has no effect. The counters and the state evolve exactly as they would without it.
- R8: While `listen_only` is 1, `drv_en` is 0 whatever `drv_req` holds. The bit positions are: bit 0 data/remote frame, bit 1 error flag, bit 2 acknowledge.
- R9: With `listen_only` at 0, `drv_en` is 0 while the node is bus off. Otherwise, bits 0 and 2 follow `drv_req`, and bit 1 follows `drv_req[1]` only in error active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_err | input | 1 | Receive error event |
| rx_err_dom | input | 1 | Receive error due to dominant bit (+8) |
| rx_ok | input | 1 | Successful reception event |
| tx_err | input | 1 | Transmit error event |
| tx_ok | input | 1 | Successful transmission event |
| force_ret | input | 1 | Software strobe: forced return from bus off |
| listen_only | input | 1 | Silence all bus driving |
| drv_req | input | 3 | Drive requests {ack, error flag, frame} |
| rec | output | 8 | Receive error counter |
| tec | output | 9 | Transmit error counter |
| err_state | output | 2 | 0 active, 1 passive, 2 bus off |
| bus_off | output | 1 | Bus-off status flag |
| drv_en | output | 3 | Qualified drive enables, same bit order as drv_req |

## Verification
Two situations can land on the same clock edge. In the first, a force-return strobe arrives together with counter events. In the second, a transmit error pushes the counter past 255 while a force strobe that should be ignored is also present. The bench provokes both with a seeded sweep whose phases bias the events toward saturating the receive counter, driving the node bus off and recovering it. Strobes and listen-only toggles are laid over every phase. Each cycle, an arithmetic model in the bench predicts the counters, the state and the enables, and the bench judges the edge by comparing them. Discarded events and ignored strobes therefore show up directly as counter mismatches.

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int REC_W       = 8,
  parameter int TEC_W       = 9,
  parameter int ERR_STEP    = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_err,
  input  logic             rx_err_dom,
  input  logic             rx_ok,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             force_ret,
  input  logic             listen_only,
  input  logic [2:0]       drv_req,
  output logic [REC_W-1:0] rec,
  output logic [TEC_W-1:0] tec,
  output logic [1:0]       err_state,
  output logic             bus_off,
  output logic [2:0]       drv_en
);
  localparam logic [REC_W:0]   REC_STEP = (REC_W+1)'(ERR_STEP);
  localparam logic [TEC_W:0]   TEC_STEP = (TEC_W+1)'(ERR_STEP);
  localparam logic [REC_W-1:0] REC_PAS  = REC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_PAS  = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_BO   = TEC_W'(BUSOFF_LIM);

  logic [REC_W-1:0] rec_q, rec_nxt;
  logic [TEC_W-1:0] tec_q, tec_nxt;
  logic             bo_q, passive;
  logic [REC_W:0]   rec_sum;
  logic [TEC_W:0]   tec_sum;

  assign rec_sum = {1'b0, rec_q} + (rx_err_dom ? REC_STEP : (REC_W+1)'(1));
  assign tec_sum = {1'b0, tec_q} + TEC_STEP;

  always_comb begin
    if (rx_err_dom || rx_err)
      rec_nxt = rec_sum[REC_W] ? '1 : rec_sum[REC_W-1:0];
    else if (rx_ok && rec_q != '0)
      rec_nxt = rec_q - 1'b1;
    else
      rec_nxt = rec_q;

    if (tx_err)
      tec_nxt = tec_sum[TEC_W] ? '1 : tec_sum[TEC_W-1:0];
    else if (tx_ok && tec_q != '0)
      tec_nxt = tec_q - 1'b1;
    else
      tec_nxt = tec_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_q <= '0;
      tec_q <= '0;
      bo_q  <= 1'b0;
    end else if (bo_q) begin
      if (force_ret) begin
        rec_q <= '0;
        tec_q <= '0;
        bo_q  <= 1'b0;
      end
    end else begin
      rec_q <= rec_nxt;
      tec_q <= tec_nxt;
      bo_q  <= (tec_nxt >= TEC_BO);
    end
  end

  assign passive   = (rec_q >= REC_PAS) || (tec_q >= TEC_PAS);
  assign rec       = rec_q;
  assign tec       = tec_q;
  assign bus_off   = bo_q;
  assign err_state = bo_q ? 2'd2 : (passive ? 2'd1 : 2'd0);
  assign drv_en    = (listen_only || bo_q) ? 3'b000
                   : {drv_req[2], drv_req[1] & ~passive, drv_req[0]};

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) err_state != 2'd3); // R4
  AST_REC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rec == '1 && !rx_ok && !bus_off) |=> rec == '1); // R2
  AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> tec >= TEC_BO); // R5
  AST_BUSOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !force_ret) |=> ($stable(rec) && $stable(tec) && bus_off)); // R5
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && force_ret) |=> (rec == '0 && tec == '0 && !bus_off && err_state == 2'd0)); // R6
  AST_FORCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off && force_ret && !rx_err && !rx_err_dom && !rx_ok && !tx_err && !tx_ok)
    |=> ($stable(rec) && $stable(tec))); // R7
  AST_LISTEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    listen_only |-> drv_en == 3'b000); // R8
  AST_BUSOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> drv_en == 3'b000); // R9
endmodule

// File: tb/sim_can_fault_conf.sv
`timescale 1ns/1ps
module sim_can_fault_conf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_err = 0, rx_err_dom = 0, rx_ok = 0, tx_err = 0, tx_ok = 0;
  logic force_ret = 0, listen_only = 0;
  logic [2:0] drv_req = '0;
  logic [7:0] rec;
  logic [8:0] tec;
  logic [1:0] err_state;
  logic bus_off;
  logic [2:0] drv_en;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_rec = 0, m_tec = 0, m_bo = 0;
  int unsigned seed = 32'h1234_5678;
  int n_bo = 0, n_force_bo = 0, n_rec_sat = 0;

  always #2.5 clk = ~clk;

  can_fault_conf u0 (.clk, .rst_n, .rx_err, .rx_err_dom, .rx_ok, .tx_err, .tx_ok,
    .force_ret, .listen_only, .drv_req, .rec, .tec, .err_state, .bus_off, .drv_en);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic step();
    int e_state, e_drv, pas;
    string tr, tt;
    tr = "R2"; tt = "R3";
    if (force_ret) begin
      tr = (m_bo != 0) ? "R6" : "R7";
      tt = tr;
    end
    if (m_bo != 0) begin
      if (force_ret) begin m_rec = 0; m_tec = 0; m_bo = 0; n_force_bo++; end
    end else begin
      if (rx_err_dom) m_rec = (m_rec + 8 > 255) ? 255 : m_rec + 8;
      else if (rx_err) m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
      else if (rx_ok && m_rec > 0) m_rec = m_rec - 1;
      if (tx_err) m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
      else if (tx_ok && m_tec > 0) m_tec = m_tec - 1;
      m_bo = (m_tec > 255) ? 1 : 0;
      if (m_bo != 0) n_bo++;
    end
    if (m_rec == 255) n_rec_sat++;
    @(posedge clk); #1;
    pas = (m_rec >= 128 || m_tec >= 128) ? 1 : 0;
    e_state = (m_bo != 0) ? 2 : pas;
    if (listen_only || m_bo != 0) e_drv = 0;
    else e_drv = {drv_req[2], drv_req[1] & (pas == 0), drv_req[0]};
    chk(tr, int'(rec), m_rec);
    chk(tt, int'(tec), m_tec);
    chk("R4", int'(err_state), e_state);
    chk("R5", int'(bus_off), m_bo);
    chk(listen_only ? "R8" : "R9", int'(drv_en), e_drv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", int'(rec), 0);
    chk("R1", int'(tec), 0);
    chk("R1", int'(err_state), 0);
    chk("R1", int'(bus_off), 0);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      int unsigned a, b;
      int ph;
      int w_rxe, w_dom, w_rok, w_txe, w_tok, w_frc;
      @(negedge clk);
      ph = (cyc / 500) % 4;
      case (ph)
        0: begin w_rxe = 60; w_dom = 30; w_rok = 40; w_txe = 15; w_tok = 60; w_frc = 6; end
        1: begin w_rxe = 60; w_dom = 120; w_rok = 10; w_txe = 20; w_tok = 40; w_frc = 3; end
        2: begin w_rxe = 30; w_dom = 20; w_rok = 30; w_txe = 140; w_tok = 20; w_frc = 5; end
        default: begin w_rxe = 10; w_dom = 5; w_rok = 200; w_txe = 10; w_tok = 200; w_frc = 12; end
      endcase
      a = nxt(); b = nxt();
      rx_err     = int'(a[7:0])   < w_rxe;
      rx_err_dom = int'(a[15:8])  < w_dom;
      rx_ok      = int'(a[23:16]) < w_rok;
      tx_err     = int'(a[31:24]) < w_txe;
      tx_ok      = int'(b[7:0])   < w_tok;
      force_ret  = int'(b[15:8])  < w_frc;
      drv_req    = b[18:16];
      if (cyc % 64 == 0) listen_only = b[20];
      step();
    end
    // R6: force together with every event while bus off
    @(negedge clk);
    {rx_err, rx_err_dom, rx_ok, tx_ok, force_ret, listen_only} = '0;
    drv_req = 3'b111;
    while (m_bo == 0) begin tx_err = 1; step(); @(negedge clk); end
    {rx_err, rx_err_dom, rx_ok, tx_err, tx_ok, force_ret} = 6'b111111;
    step();
    @(negedge clk);
    {rx_err, rx_err_dom, rx_ok, tx_err, tx_ok, force_ret} = '0;
    step();
    // R7: force while not bus off, same cycle as the crossing transmit error
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      tx_err = 1; force_ret = (k == 31);
      step();
    end
    chk("R7", int'(bus_off), 1);
    chk("R5", (n_bo > 2) ? 1 : 0, 1);
    chk("R6", (n_force_bo > 2) ? 1 : 0, 1);
    chk("R2", (n_rec_sat > 0) ? 1 : 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule